// File: doc/BRIEF.md
# Per-Lane Receive Delay Training Calibrator

This block trains the input delay of every lane of a double-data-rate, source-synchronous receive bus. While the transmitter sends a known training pattern, the block walks a shared sweep tap across the whole delay range. At each tap it waits for the delay line to settle. It then compares, over a dwell window, the rising-edge and falling-edge bits captured on every lane against the expected bits for that lane. Each lane keeps its own record of which taps passed.

When the sweep ends, every lane is given the tap at the middle of its own longest unbroken run of passing taps. A lane that never passed is flagged through its own fail bit. The delay elements, the I/O buffers and the clock-domain crossing sit outside this block. Any lane grouping by forwarded clock is done by the instantiating logic, which only needs one calibrator per clock domain or one shared calibrator.

Use: hold the transmitter in training mode, pulse `start`, and wait for `done`. Each lane then has its final tap on `tapValue` with a `tapLoad` strobe. Pulsing `start` again repeats the whole procedure.

Top module: `ddr_tap_trainer`

## Requirements
- R1: After reset every lane's tap is 0, and `tapLoad`, `done` and every `fail` bit are 0.
- R2: A `start` pulse seen while idle sets every lane's tap to 0 with a `tapLoad` pulse. Each later sweep step raises every lane's tap by exactly one with a `tapLoad` pulse, up to 2**TAP_W-1. That makes 2**TAP_W sweep loads.
- R3: For SETTLE_CYCLES cycles after each tap load, beginning with the cycle in which `tapLoad` is high, the captured bits are not compared, so mismatches there do not affect the result.
- R4: A tap passes on a lane only if, in each of the DWELL_CYCLES cycles that follow the settle time, both the rising bit equals `expRise` and the falling bit equals `expFall`. A single mismatch in either bit, including one in the first or the last dwell cycle, fails that tap.
- R5: Each lane's pass or fail result, run tracking and final tap depend only on that lane's own captured and expected bits.
- R6: Only the longest contiguous run of passing taps is used. When two runs are equally long, the one starting at the lower tap wins.
- R7: The final tap of a lane is start + floor((length-1)/2) of its chosen run. This is the midpoint of the first and last passing tap, rounded down.
- R8: A lane with no passing tap gets its `fail` bit set and a final tap of 0.
- R9: The final taps and fail bits appear together with one `tapLoad` pulse. `done` goes high for exactly one cycle, in the cycle after that pulse.
- R10: A further `start` after `done` reruns the full sweep from tap 0 and clears the old fail bits at the first load.
- R11: `tapValue` and `fail` change only in cycles in which `tapLoad` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calibration; accepted only while idle |
| capRise | input | NUM_LANES | Bit captured on the rising edge, one per lane |
| capFall | input | NUM_LANES | Bit captured on the falling edge, one per lane |
| expRise | input | NUM_LANES | Expected rising-edge training bit per lane |
| expFall | input | NUM_LANES | Expected falling-edge training bit per lane |
| tapValue | output | NUM_LANES*TAP_W | Delay tap per lane, lane n at bits n*TAP_W upward |
| tapLoad | output | 1 | One-cycle strobe: apply tapValue to the delay elements |
| done | output | 1 | One-cycle pulse once the final taps are loaded |
| fail | output | NUM_LANES | Lane found no passing tap |

## Verification
The bench models a delay line for every lane with a fixed 32-bit mask of good taps and computes each expected centre tap from that mask. The masks cover single-tap windows at both ends of the range, a fully open range, an empty one, two separated runs of different lengths, equal-length ties and even-length windows. Together these separate longest-run selection, tie order and rounding.

On good taps the model corrupts the capture only during the settle time, which shows that unsettled cycles are not compared. On bad taps it corrupts a single bit in just the first or just the last dwell cycle, on the rising bit for even lanes and the falling bit for odd lanes. This shows that one error at either end of the window, on either edge, is enough to fail a tap. A rerun with new masks, followed by a return to the first set, confirms that no state carries over between runs.

// File: rtl/tap_trainer_pkg.sv
package tap_trainer_pkg;

  // Strobes issued by the sequencer to the datapath, at most a few per cycle.
  typedef struct packed {
    logic sweepReset;  // start of a run: tap 0 everywhere, clear trackers
    logic compare;     // dwell cycle: compare captured against expected
    logic evaluate;    // end of dwell: fold pass result into run tracking
    logic stepTap;     // move sweep to next tap
    logic commit;      // program centre taps and fail flags
  } trainStrobe_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DWELL,
    ST_NEXT,
    ST_FINAL,
    ST_DONE
  } trainState_t;

endpackage

// File: rtl/tap_train_ctrl.sv
module tap_train_ctrl
  import tap_trainer_pkg::*;
#(
  parameter int SETTLE_CYCLES = 16,
  parameter int DWELL_CYCLES  = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         lastTap,
  output trainStrobe_t strobe,
  output logic         done
);

  localparam int MAX_WAIT = (SETTLE_CYCLES > DWELL_CYCLES) ? SETTLE_CYCLES : DWELL_CYCLES;
  localparam int CNT_W    = $clog2(MAX_WAIT + 1);
  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DWELL_LAST  = CNT_W'(DWELL_CYCLES - 1);

  trainState_t state;
  logic [CNT_W-1:0] waitCnt;

  always_comb begin
    strobe = '0;
    case (state)
      ST_IDLE:  strobe.sweepReset = start;
      ST_DWELL: strobe.compare    = 1'b1;
      ST_NEXT: begin
        strobe.evaluate = 1'b1;
        strobe.stepTap  = !lastTap;
      end
      ST_FINAL: strobe.commit = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= (state == ST_DONE);
      case (state)
        ST_IDLE: begin
          waitCnt <= '0;
          if (start) state <= ST_SETTLE;
        end
        ST_SETTLE: begin
          if (waitCnt == SETTLE_LAST) begin
            waitCnt <= '0;
            state   <= ST_DWELL;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_DWELL: begin
          if (waitCnt == DWELL_LAST) begin
            waitCnt <= '0;
            state   <= ST_NEXT;
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        ST_NEXT:  state <= lastTap ? ST_FINAL : ST_SETTLE;
        ST_FINAL: state <= ST_DONE;
        ST_DONE:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tap_lane_tracker.sv
module tap_lane_tracker
  import tap_trainer_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  trainStrobe_t     strobe,
  input  logic [TAP_W-1:0] sweepTap,
  input  logic             capRise,
  input  logic             capFall,
  input  logic             expRise,
  input  logic             expFall,
  output logic [TAP_W-1:0] tap,
  output logic             fail
);

  localparam int LEN_W = TAP_W + 1;

  logic             passFlag;
  logic [TAP_W-1:0] curStart, bestStart;
  logic [LEN_W-1:0] curLen, bestLen;
  logic [LEN_W-1:0] grownLen;
  logic [TAP_W-1:0] grownStart;
  logic [LEN_W-1:0] halfSpan;
  logic             mismatch;

  assign mismatch   = (capRise ^ expRise) | (capFall ^ expFall);
  assign grownLen   = curLen + 1'b1;
  assign grownStart = (curLen == '0) ? sweepTap : curStart;
  assign halfSpan   = (bestLen - 1'b1) >> 1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      passFlag  <= 1'b1;
      curStart  <= '0;
      curLen    <= '0;
      bestStart <= '0;
      bestLen   <= '0;
      tap       <= '0;
      fail      <= 1'b0;
    end else begin
      if (strobe.sweepReset || strobe.stepTap) passFlag <= 1'b1;
      else if (strobe.compare && mismatch)     passFlag <= 1'b0;

      if (strobe.sweepReset) begin
        curStart  <= '0;
        curLen    <= '0;
        bestStart <= '0;
        bestLen   <= '0;
        tap       <= '0;
        fail      <= 1'b0;
      end else begin
        if (strobe.evaluate) begin
          if (passFlag) begin
            curLen   <= grownLen;
            curStart <= grownStart;
            if (grownLen > bestLen) begin
              bestLen   <= grownLen;
              bestStart <= grownStart;
            end
          end else begin
            curLen <= '0;
          end
        end
        if (strobe.stepTap) tap <= sweepTap + 1'b1;
        if (strobe.commit) begin
          fail <= (bestLen == '0);
          tap  <= (bestLen == '0) ? '0 : bestStart + halfSpan[TAP_W-1:0];
        end
      end
    end
  end

endmodule

// File: rtl/tap_train_datapath.sv
module tap_train_datapath
  import tap_trainer_pkg::*;
#(
  parameter int NUM_LANES = 24,
  parameter int TAP_W     = 5
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  trainStrobe_t               strobe,
  input  logic [NUM_LANES-1:0]       capRise,
  input  logic [NUM_LANES-1:0]       capFall,
  input  logic [NUM_LANES-1:0]       expRise,
  input  logic [NUM_LANES-1:0]       expFall,
  output logic                       lastTap,
  output logic [NUM_LANES*TAP_W-1:0] tapValue,
  output logic                       tapLoad,
  output logic [NUM_LANES-1:0]       fail
);

  logic [TAP_W-1:0] sweepTap;

  assign lastTap = (sweepTap == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sweepTap <= '0;
      tapLoad  <= 1'b0;
    end else begin
      tapLoad <= strobe.sweepReset | strobe.stepTap | strobe.commit;
      if (strobe.sweepReset)   sweepTap <= '0;
      else if (strobe.stepTap) sweepTap <= sweepTap + 1'b1;
    end
  end

  for (genvar lane = 0; lane < NUM_LANES; lane++) begin : g_lane
    tap_lane_tracker #(.TAP_W(TAP_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .strobe   (strobe),
      .sweepTap (sweepTap),
      .capRise  (capRise[lane]),
      .capFall  (capFall[lane]),
      .expRise  (expRise[lane]),
      .expFall  (expFall[lane]),
      .tap      (tapValue[lane*TAP_W +: TAP_W]),
      .fail     (fail[lane])
    );
  end

endmodule

// File: rtl/ddr_tap_trainer.sv
module ddr_tap_trainer
  import tap_trainer_pkg::*;
#(
  parameter int NUM_LANES     = 24,
  parameter int TAP_W         = 5,
  parameter int SETTLE_CYCLES = 16,
  parameter int DWELL_CYCLES  = 256
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [NUM_LANES-1:0]       capRise,
  input  logic [NUM_LANES-1:0]       capFall,
  input  logic [NUM_LANES-1:0]       expRise,
  input  logic [NUM_LANES-1:0]       expFall,
  output logic [NUM_LANES*TAP_W-1:0] tapValue,
  output logic                       tapLoad,
  output logic                       done,
  output logic [NUM_LANES-1:0]       fail
);

  trainStrobe_t strobe;
  logic         lastTap;

  tap_train_ctrl #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .DWELL_CYCLES  (DWELL_CYCLES)
  ) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .lastTap (lastTap),
    .strobe  (strobe),
    .done    (done)
  );

  tap_train_datapath #(
    .NUM_LANES (NUM_LANES),
    .TAP_W     (TAP_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (strobe),
    .capRise  (capRise),
    .capFall  (capFall),
    .expRise  (expRise),
    .expFall  (expFall),
    .lastTap  (lastTap),
    .tapValue (tapValue),
    .tapLoad  (tapLoad),
    .fail     (fail)
  );

endmodule

// File: rtl/ddr_tap_trainer_checker.sv
module ddr_tap_trainer_checker #(
  parameter int NUM_LANES = 24,
  parameter int TAP_W     = 5
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_LANES*TAP_W-1:0] tapValue,
  input logic                       tapLoad,
  input logic                       done,
  input logic [NUM_LANES-1:0]       fail
);

  logic [NUM_LANES-1:0] laneTapZero;

  always_comb begin
    for (int i = 0; i < NUM_LANES; i++)
      laneTapZero[i] = (tapValue[i*TAP_W +: TAP_W] == '0);
  end

  // R9: done comes exactly one cycle after the final load
  a_r9_done_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tapLoad));

  // R9: done is a single-cycle pulse
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a failed lane reports tap 0 when done
  a_r8_fail_tap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((laneTapZero & fail) == fail));

  // R11: taps move only with a load strobe
  a_r11_tap_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tapLoad |-> $stable(tapValue));

  // R11: fail flags move only with a load strobe
  a_r11_fail_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tapLoad |-> $stable(fail));

endmodule

bind ddr_tap_trainer ddr_tap_trainer_checker #(
  .NUM_LANES (NUM_LANES),
  .TAP_W     (TAP_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tapValue (tapValue),
  .tapLoad  (tapLoad),
  .done     (done),
  .fail     (fail)
);

// File: tb/ddr_tap_trainer_test.sv
module ddr_tap_trainer_test;

  localparam int LANES  = 8;
  localparam int TW     = 5;
  localparam int NTAPS  = 1 << TW;
  localparam int SETTLE = 4;
  localparam int DWELL  = 16;

  logic                  clk = 1'b0;
  logic                  rst_n = 1'b0;
  logic                  start = 1'b0;
  logic [LANES-1:0]      capRise = '0, capFall = '0, expRise = '0, expFall = '0;
  logic [LANES*TW-1:0]   tapValue;
  logic                  tapLoad;
  logic                  done;
  logic [LANES-1:0]      fail;

  logic [NTAPS-1:0] laneMask [LANES];
  int  checks = 0;
  int  errors = 0;
  int  sinceLoad = 0;
  int  cyc = 0;
  bit  finished = 0;

  always #2.5 clk = ~clk;

  ddr_tap_trainer #(
    .NUM_LANES(LANES), .TAP_W(TW), .SETTLE_CYCLES(SETTLE), .DWELL_CYCLES(DWELL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .capRise(capRise), .capFall(capFall), .expRise(expRise), .expFall(expFall),
    .tapValue(tapValue), .tapLoad(tapLoad), .done(done), .fail(fail)
  );

  // Delay-line model: good taps are corrupted only while settling (R3);
  // bad taps get one error in the first or last dwell cycle (R4), on the
  // rising bit for even lanes and the falling bit for odd lanes.
  always @(negedge clk) begin
    cyc++;
    if (tapLoad) sinceLoad = 0;
    else if (sinceLoad < 100000) sinceLoad++;
    for (int l = 0; l < LANES; l++) begin
      logic [TW-1:0] t;
      logic er, ef, badR, badF;
      t  = tapValue[l*TW +: TW];
      er = ((cyc >> (l % 5)) & 1) != 0;
      ef = er ^ (((cyc >> 1) & 1) != 0) ^ l[0];
      badR = 1'b0;
      badF = 1'b0;
      if (laneMask[l][t]) begin
        if (sinceLoad < SETTLE) begin badR = 1'b1; badF = 1'b1; end
      end else begin
        if ((t[0] && sinceLoad == SETTLE + DWELL - 1) || (!t[0] && sinceLoad == SETTLE)) begin
          if (l[0]) badF = 1'b1; else badR = 1'b1;
        end
      end
      expRise[l] = er;
      expFall[l] = ef;
      capRise[l] = er ^ badR;
      capFall[l] = ef ^ badF;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int runRange(input int lo, input int hi);
    logic [NTAPS-1:0] m = '0;
    for (int t = lo; t <= hi; t++) m[t] = 1'b1;
    return int'(m);
  endfunction

  // Expected centre from the requirement: longest run, lowest start on tie (R6),
  // start + floor((len-1)/2) (R7), failure -> 0 (R8).
  task automatic expectFor(input logic [NTAPS-1:0] m, output int c, output bit f);
    int bs = 0, bl = 0, cs = 0, cl = 0;
    for (int t = 0; t < NTAPS; t++) begin
      if (m[t]) begin
        if (cl == 0) cs = t;
        cl++;
        if (cl > bl) begin bl = cl; bs = cs; end
      end else cl = 0;
    end
    f = (bl == 0);
    c = f ? 0 : bs + (bl - 1) / 2;
  endtask

  task automatic runCal(input string tag);
    int loadCnt = 0;
    int lastLoad = -10;
    int doneAt = -1;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (tapLoad) begin
        if (loadCnt < NTAPS) begin
          bit ok = 1;
          int bad = 0;
          for (int l = 0; l < LANES; l++)
            if (int'(tapValue[l*TW +: TW]) != loadCnt) begin ok = 0; bad = int'(tapValue[l*TW +: TW]); end
          // R2 sweep order; R10 rerun restarts at tap 0 with fail cleared
          check(ok, "R2 sweep tap", bad, loadCnt);
          if (loadCnt == 0) check(fail == '0, "R10 fail cleared at first load", int'(fail), 0);
        end
        loadCnt++;
        lastLoad = i;
      end
      if (done) begin doneAt = i; break; end
      @(negedge clk);
    end
    check(doneAt >= 0, "R9 done reached", doneAt, 1);
    check(loadCnt == NTAPS + 1, "R2 load count", loadCnt, NTAPS + 1);
    check(lastLoad == doneAt - 1, "R9 done one cycle after final load", lastLoad, doneAt - 1);
    for (int l = 0; l < LANES; l++) begin
      int c; bit f;
      expectFor(laneMask[l], c, f);
      // R5 per-lane result; R6/R7 centre; R8 fail; R3/R4 via the model
      check(int'(tapValue[l*TW +: TW]) == c, "R7 final tap", int'(tapValue[l*TW +: TW]), c);
      check(fail[l] == f, "R8 fail flag", int'(fail[l]), int'(f));
    end
    @(negedge clk);
    check(done == 1'b0, "R9 done single cycle", int'(done), 0);
    $display("run %s complete", tag);
  endtask

  task automatic setRun1();
    laneMask[0] = runRange(3, 12);                       // centre 7
    laneMask[1] = runRange(0, 0);                        // lower edge
    laneMask[2] = runRange(31, 31);                      // upper edge
    laneMask[3] = runRange(0, 31);                       // open eye -> 15
    laneMask[4] = '0;                                    // R8 none
    laneMask[5] = runRange(2, 4) | runRange(10, 17);     // R6 longer wins -> 13
    laneMask[6] = runRange(1, 3) | runRange(20, 22);     // R6 tie -> 2
    laneMask[7] = runRange(5, 8);                        // even length -> 6
  endtask

  task automatic setRun2();
    laneMask[0] = runRange(0, 1);
    laneMask[1] = runRange(30, 31);
    laneMask[2] = runRange(4, 9);
    laneMask[3] = '0;
    laneMask[4] = runRange(0, 5) | runRange(7, 12);
    laneMask[5] = runRange(10, 14) | runRange(16, 20);
    laneMask[6] = runRange(29, 31) | runRange(0, 1);
    laneMask[7] = runRange(17, 17);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    setRun1();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(tapValue == '0, "R1 taps zero", int'(tapValue[TW-1:0]), 0);
    check(tapLoad == 1'b0, "R1 no load", int'(tapLoad), 0);
    check(done == 1'b0, "R1 no done", int'(done), 0);
    check(fail == '0, "R1 no fail", int'(fail), 0);
    runCal("first");
    setRun2();
    runCal("second");   // R10 rerun with new eyes
    setRun1();
    runCal("third");
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule